// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit resolves the operand of one instruction under one of eight addressing modes. For each request it takes a mode code, an address field, a register number, the value read from the register file for that register, and the current program counter. Three kinds of result come back: an immediate operand, a register tag, or a final effective address. A one-cycle done strobe marks the result.

Some modes can be resolved from the request alone, and these finish one cycle after the start. The others need memory. Indirect, pre-indexed indirect and post-indexed indirect modes issue word reads on a simple request/valid port, and a sequencer chains the reads: up to four levels of pointer following for indirect mode, and one read, either before or after the register add, for the two indexed indirect forms. The register value and PC are captured in the start cycle. Instruction decode, the register file and the later data access belong to the neighbouring blocks.

Top module: `ea_unit`

## Requirements
- R1: Mode 0 (immediate) returns result kind 0 with the value equal to the address field, one cycle after start, and issues no memory request.
- R2: Mode 1 (direct) returns result kind 2 (effective address) with the value equal to the address field, and issues no memory request.
- R3: Mode 2 (indirect) issues depth+1 reads (depth input 0..3). The first read is at the address field and each later read is at the word returned by the one before. The last word returned is the effective address (kind 2).
- R4: Mode 3 (register) returns result kind 1 with the value equal to the zero-extended register number, and issues no memory request.
- R5: Mode 4 (register indirect) returns kind 2 with the value equal to the register value captured at start, and issues no memory request.
- R6: Mode 5 (displacement) returns kind 2 with the address field plus the register value, modulo 2^AW, and issues no memory request.
- R7: Mode 6 (relative) returns kind 2 with the address field plus the PC, modulo 2^AW, and issues no memory request.
- R8: Mode 7 with pre_sel=0 (post-indexed) reads once at the address field. The result is the word read plus the register value, as kind 2.
- R9: Mode 7 with pre_sel=1 (pre-indexed) reads once at the address field plus the register value. The result is the word read, as kind 2.
- R10: busy rises on the edge that accepts a start and stays high through the done cycle. done is high for exactly one cycle, and busy is low in the cycle after done.
- R11: A start while busy, including in the done cycle, is ignored. The result is not altered and no extra done follows.
- R12: mem_req stays high with a stable mem_addr until mem_valid is seen. It is high only while busy and before done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving one operand (taken only when idle) |
| mode | input | 3 | Addressing mode code 0..7 |
| pre_sel | input | 1 | In mode 7: 1 = add before the read, 0 = add after it |
| depth | input | DW | Indirect levels minus one |
| addr_field | input | AW | Address field of the instruction |
| reg_num | input | RW | Register number |
| reg_data | input | AW | Register file read data for reg_num |
| pc | input | AW | Current program counter |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Read address |
| mem_valid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | AW | Read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 0 immediate, 1 register tag, 2 effective address |
| res_value | output | AW | Result value |

## Verification
The collisions of interest are a new start in the same cycle as done, and a read completing in the very first cycle of its request. The bench holds start high through the whole of a long indirect chain and through the done cycle. It then checks that busy drops on the next cycle, that the earlier result is kept and that no second done follows. The memory responder is swept over zero, one and two wait cycles, so that valid arrives together with a fresh request as well as after a stall. For every setting, the read addresses and final values are compared with arithmetic computed in the bench.

// File: rtl/ea_pkg.sv
// Shared encodings for the effective address unit.
// Assumes a 3-bit mode code and a 2-bit result kind.
package ea_pkg;
    typedef enum logic [2:0] {
        MODE_IMM  = 3'd0,
        MODE_DIR  = 3'd1,
        MODE_IND  = 3'd2,
        MODE_REG  = 3'd3,
        MODE_RIND = 3'd4,
        MODE_DISP = 3'd5,
        MODE_REL  = 3'd6,
        MODE_IDX  = 3'd7
    } ea_mode_e;

    typedef enum logic [1:0] {
        KIND_IMM = 2'd0,
        KIND_REG = 2'd1,
        KIND_EA  = 2'd2
    } ea_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_DONE = 2'd2
    } ea_state_e;
endpackage

// File: rtl/ea_comb_calc.sv
// Combinational decode of one request. It produces the result for modes
// that need no memory, and the launch parameters for the modes that do.
// Assumes AW > RW and that inputs are stable in the start cycle.
module ea_comb_calc
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 3,
    parameter int DW = 2
) (
    input  logic [2:0]    mode,
    input  logic          pre_sel,
    input  logic [DW-1:0] depth,
    input  logic [AW-1:0] addr_field,
    input  logic [RW-1:0] reg_num,
    input  logic [AW-1:0] reg_data,
    input  logic [AW-1:0] pc,
    output ea_kind_e      kind,
    output logic [AW-1:0] value,
    output logic          needs_mem,
    output logic [AW-1:0] first_ptr,
    output logic [DW-1:0] levels,
    output logic          post_add
);
    localparam int PADW = AW - RW;

    ea_mode_e      m;
    logic [AW-1:0] base;
    logic [AW-1:0] sum;

    assign m = ea_mode_e'(mode);

    // Select the base of the single adder: the PC for relative mode, the register otherwise
    assign base = (m == MODE_REL) ? pc : reg_data;
    assign sum  = addr_field + base;

    // Decode the mode into a result or into a memory launch
    always_comb begin
        kind      = KIND_EA;
        value     = addr_field;
        needs_mem = 1'b0;
        first_ptr = addr_field;
        levels    = '0;
        post_add  = 1'b0;
        case (m)
            MODE_IMM:  kind = KIND_IMM;
            MODE_DIR:  kind = KIND_EA;
            MODE_IND: begin
                needs_mem = 1'b1;
                levels    = depth;
            end
            MODE_REG: begin
                kind  = KIND_REG;
                value = {{PADW{1'b0}}, reg_num};
            end
            MODE_RIND: value = reg_data;
            MODE_DISP: value = sum;
            MODE_REL:  value = sum;
            MODE_IDX: begin
                needs_mem = 1'b1;
                if (pre_sel) first_ptr = sum;
                else         post_add  = 1'b1;
            end
            default: kind = KIND_EA;
        endcase
    end
endmodule

// File: rtl/ea_mem_seq.sv
// Read sequencer: follows a chain of 1 to 2^DW pointers over a
// request/valid port. It can add a captured index to the final word.
// Assumes launch is only raised while the sequencer is inactive.
module ea_mem_seq #(
    parameter int AW = 16,
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] launch_ptr,
    input  logic [DW-1:0] launch_levels,
    input  logic          launch_post,
    input  logic [AW-1:0] launch_idx,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_rdata,
    output logic          fin,
    output logic [AW-1:0] fin_value
);
    logic          active;
    logic [AW-1:0] ptr;
    logic [DW-1:0] left;
    logic          post;
    logic [AW-1:0] idx;

    assign mem_req   = active;
    assign mem_addr  = ptr;
    assign fin       = active && mem_valid && (left == '0);
    assign fin_value = mem_rdata + (post ? idx : '0);

    // Capture a launch, then step through the chain on each accepted read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ptr    <= '0;
            left   <= '0;
            post   <= 1'b0;
            idx    <= '0;
        end else if (launch) begin
            active <= 1'b1;
            ptr    <= launch_ptr;
            left   <= launch_levels;
            post   <= launch_post;
            idx    <= launch_idx;
        end else if (active && mem_valid) begin
            ptr <= mem_rdata;
            if (left == '0) active <= 1'b0;
            else            left   <= left - 1'b1;
        end
    end
endmodule

// File: rtl/ea_unit.sv
// Effective address unit top. It accepts one request while idle. Modes
// without memory finish one cycle after start. The others run the read
// sequencer and finish when the last read returns.
// Assumes reg_data and pc belong to the start cycle only.
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 3,
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic          pre_sel,
    input  logic [DW-1:0] depth,
    input  logic [AW-1:0] addr_field,
    input  logic [RW-1:0] reg_num,
    input  logic [AW-1:0] reg_data,
    input  logic [AW-1:0] pc,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [1:0]    res_kind,
    output logic [AW-1:0] res_value
);
    ea_state_e     st;
    ea_kind_e      c_kind;
    logic [AW-1:0] c_value;
    logic          c_needs;
    logic [AW-1:0] c_ptr;
    logic [DW-1:0] c_levels;
    logic          c_post;
    logic          accept;
    logic          seq_fin;
    logic [AW-1:0] seq_value;
    ea_kind_e      kind_q;

    assign accept   = start && (st == ST_IDLE);
    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_DONE);
    assign res_kind = kind_q;

    ea_comb_calc #(.AW(AW), .RW(RW), .DW(DW)) u_calc (
        .mode       (mode),
        .pre_sel    (pre_sel),
        .depth      (depth),
        .addr_field (addr_field),
        .reg_num    (reg_num),
        .reg_data   (reg_data),
        .pc         (pc),
        .kind       (c_kind),
        .value      (c_value),
        .needs_mem  (c_needs),
        .first_ptr  (c_ptr),
        .levels     (c_levels),
        .post_add   (c_post)
    );

    ea_mem_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch        (accept && c_needs),
        .launch_ptr    (c_ptr),
        .launch_levels (c_levels),
        .launch_post   (c_post),
        .launch_idx    (reg_data),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_valid     (mem_valid),
        .mem_rdata     (mem_rdata),
        .fin           (seq_fin),
        .fin_value     (seq_value)
    );

    // Request state machine and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            kind_q    <= KIND_IMM;
            res_value <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    if (c_needs) begin
                        st <= ST_MEM;
                    end else begin
                        st        <= ST_DONE;
                        kind_q    <= c_kind;
                        res_value <= c_value;
                    end
                end
                ST_MEM: if (seq_fin) begin
                    st        <= ST_DONE;
                    kind_q    <= KIND_EA;
                    res_value <= seq_value;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ea_unit_checker.sv
// Protocol properties of the effective address unit, bound to the top.
module ea_unit_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    mode,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_valid
);
    p_done_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_busy_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_start_in_done_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
    p_req_inside_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done));
    // Covers R1, R2, R4, R5, R6 and R7: memoryless modes finish next cycle
    p_nomem_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode != 3'd2 && mode != 3'd7) |=> (done && !mem_req));
endmodule

bind ea_unit ea_unit_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid)
);

// File: tb/test_ea_unit.sv
// Sweep bench for ea_unit: all modes, depths, memory latencies and value sets.
module test_ea_unit;
    localparam int AW = 16;
    localparam int RW = 3;
    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic          pre_sel = 1'b0;
    logic [DW-1:0] depth = '0;
    logic [AW-1:0] addr_field = '0;
    logic [RW-1:0] reg_num = '0;
    logic [AW-1:0] reg_data = '0;
    logic [AW-1:0] pc = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid;
    logic [AW-1:0] mem_rdata;
    logic          busy;
    logic          done;
    logic [1:0]    res_kind;
    logic [AW-1:0] res_value;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int waitc = 0;
    int rd_cnt = 0;
    logic [AW-1:0] rd_log [0:63];

    always #10 clk = ~clk;

    function automatic logic [AW-1:0] memf(input logic [AW-1:0] a);
        return (a ^ 16'h5A5A) + 16'h0123;
    endfunction

    assign mem_valid = mem_req && (waitc >= lat);
    assign mem_rdata = memf(mem_addr);

    // Memory responder: inserts lat wait cycles and logs accepted addresses
    always @(posedge clk) begin
        if (mem_req && !mem_valid) waitc <= waitc + 1;
        else                       waitc <= 0;
        if (mem_req && mem_valid) begin
            rd_log[rd_cnt % 64] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    ea_unit #(.AW(AW), .RW(RW), .DW(DW)) i_ea_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pre_sel(pre_sel),
        .depth(depth), .addr_field(addr_field), .reg_num(reg_num),
        .reg_data(reg_data), .pc(pc), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .res_kind(res_kind), .res_value(res_value)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m, input logic p);
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return p ? "R9" : "R8";
        endcase
    endfunction

    // One request: drive it, wait for done, compare kind, value and reads
    task automatic run_op(input int m, input logic p, input logic [AW-1:0] a,
                          input logic [RW-1:0] rn, input logic [AW-1:0] rv,
                          input logic [AW-1:0] pcv, input int d, input int l,
                          input bit hold_start);
        logic [1:0]    ek;
        logic [AW-1:0] ev;
        logic [AW-1:0] ea [0:3];
        logic [AW-1:0] ptr;
        int n;
        int base;
        int cyc;
        string tag;
        tag = mode_tag(m, p);
        ek = 2'd2; ev = a; n = 0;
        case (m)
            0: ek = 2'd0;
            1: ev = a;
            2: begin
                ptr = a;
                for (int i = 0; i <= d; i++) begin ea[i] = ptr; ptr = memf(ptr); end
                ev = ptr; n = d + 1;
            end
            3: begin ek = 2'd1; ev = {13'd0, rn}; end
            4: ev = rv;
            5: ev = a + rv;
            6: ev = a + pcv;
            default: begin
                n = 1;
                if (p) begin ea[0] = a + rv; ev = memf(a + rv); end
                else   begin ea[0] = a;      ev = memf(a) + rv; end
            end
        endcase
        @(negedge clk);
        lat = l;
        mode = 3'(m); pre_sel = p; addr_field = a; reg_num = rn;
        reg_data = rv; pc = pcv; depth = DW'(d); start = 1'b1;
        base = rd_cnt;
        @(negedge clk);
        start = hold_start;
        mode = 3'd5; addr_field = ~a; reg_data = ~rv; pc = ~pcv; reg_num = ~rn;
        cyc = 1;
        while (!done && cyc < 100) begin
            chk(busy, "R10", "busy before done", busy, 1);
            @(negedge clk);
            cyc++;
        end
        chk(done, "R10", "done reached", done, 1);
        if (n == 0) chk(cyc == 1, tag, "latency of memoryless mode", cyc, 1);
        chk(res_kind == ek, tag, "result kind", res_kind, ek);
        chk(res_value == ev, tag, "result value", res_value, ev);
        chk(rd_cnt - base == n, tag, "read count", rd_cnt - base, n);
        for (int i = 0; i < n && i < 4; i++)
            chk(rd_log[(base + i) % 64] == ea[i], tag, "read address",
                rd_log[(base + i) % 64], ea[i]);
        @(negedge clk);
        start = 1'b0;
        chk(!done && !busy, hold_start ? "R11" : "R10", "idle after done",
            {done, busy}, 0);
        if (hold_start) begin
            for (int i = 0; i < 3; i++) begin
                chk(!done, "R11", "no extra done", done, 0);
                chk(res_value == ev, "R11", "result kept", res_value, ev);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] av [0:1];
        logic [AW-1:0] rvv [0:1];
        av[0] = 16'h0010; av[1] = 16'hFFF0;
        rvv[0] = 16'h0025; rvv[1] = 16'h8031;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R10", "reset state",
            {busy, done, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 8; m++)
            for (int p = 0; p < 2; p++)
                for (int d = 0; d < 4; d++)
                    for (int l = 0; l < 3; l++)
                        for (int v = 0; v < 2; v++)
                            run_op(m, p[0], av[v], RW'(v ? 7 : 2), rvv[v],
                                   16'h7F00 + 16'(v * 16'h0300), d, l, 1'b0);
        // R11: start held through a 4-level chain with stalls and its done cycle
        run_op(2, 1'b0, 16'h1234, 3'd4, 16'h0101, 16'h0200, 3, 2, 1'b1);
        run_op(7, 1'b0, 16'h4321, 3'd1, 16'h0F0F, 16'h0300, 0, 1, 1'b1);
        run_op(0, 1'b0, 16'hBEEF, 3'd0, 16'h0000, 16'h0000, 0, 0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule